// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of up to 32 already-synchronized GPIO input pins and turns selected transitions or levels on them into a single interrupt request. Each pin has its own sensitivity, chosen from three configuration bits: edge or level, active polarity, and a both-edges override. Qualifying events are latched into a per-pin status register. Software clears a status bit by writing a 1 to it.

A per-pin mask decides which latched events reach the interrupt output. The mask cannot be written directly. One strobe register sets mask bits and another clears them. Detection and latching continue while a pin is masked. An event captured during that time therefore raises the interrupt as soon as the pin is unmasked, unless software clears its status bit first.

The block sits on a simple register bus with address, write data, write strobe, read strobe and read data. Read data is registered.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is held and on release, the mask reads all ones, status reads zero, the three configuration registers read zero and irq is low.
- R2: Word addresses 0 (edge select, 1 = edge, 0 = level), 1 (polarity, 1 = rising/high, 0 = falling/low) and 2 (both-edges, 1 = any transition) are read/write. Reads of the write-only addresses 4 and 5 return zero.
- R3: Address 3 reads the mask, where 1 means masked. A write to address 4 clears every mask bit written as 1. A write to address 5 sets every mask bit written as 1. Bits written as 0 are unchanged, so one all-ones write to address 5 masks every pin.
- R4: With edge=1, polarity=1 and both=0, a pin's status bit sets when the pin goes 0 to 1 between consecutive clocks, and not when it goes 1 to 0.
- R5: With edge=1, polarity=0 and both=0, status sets on a 1-to-0 transition only.
- R6: With edge=1 and both=1, status sets on either transition, whatever the polarity bit holds.
- R7: With edge=0, status sets on every cycle that the pin is at the active level (high when polarity=1, low when polarity=0), and the both-edges bit has no effect. A clear written while the level is still present is overridden.
- R8: Address 6 reads the latched status. Writing it clears only the bits written as 1. When a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R9: Status keeps latching while a pin is masked. Unmasking such a pin raises irq unless its status was cleared first.
- R10: irq is a register holding the OR of status AND NOT mask from the previous cycle. It rises one cycle after a status bit sets on an unmasked pin, or one cycle after an unmask, and falls one cycle after the last pending bit is cleared or masked.
- R11: Read data is captured on the clock edge that samples the read strobe. It is visible in the following cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Synchronized GPIO pin levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check four things on every cycle:
- irq follows the pending set of the previous cycle.
- A status bit only drops under a status write.
- The mask only moves under one of its two strobe registers.
- The configuration only moves under its own writes.

The bench scenarios show the rest. They cover each sensitivity mode and its ignored bits, and the override of a clear by a level that is still active. They also show that an event captured while masked is delivered on unmask, and that clearing status first prevents this. Finally, they cover the readback timing and the reset values.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO interrupt unit: register word map.
// Assumes a word-addressed bus; unused addresses read zero and ignore writes.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_EDGE    = 3'd0,
        REG_POL     = 3'd1,
        REG_BOTH    = 3'd2,
        REG_MASK    = 3'd3,
        REG_UNMASK  = 3'd4,
        REG_MASKSET = 3'd5,
        REG_STATUS  = 3'd6
    } reg_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
// Configuration and mask storage.
// Holds the three per-pin sensitivity registers and the mask, which is
// changed only through the set and clear strobes. Assumes at most one
// register write per cycle.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NPINS-1:0]      wdata,
    output logic [NPINS-1:0]      edge_sel,
    output logic [NPINS-1:0]      pol,
    output logic [NPINS-1:0]      both,
    output logic [NPINS-1:0]      mask
);
    logic [NPINS-1:0] mask_n;

    // Next mask: strobe bits set or clear, zeros leave bits untouched.
    always_comb begin
        mask_n = mask;
        if (wr && addr == REG_MASKSET) mask_n = mask | wdata;
        if (wr && addr == REG_UNMASK)  mask_n = mask & ~wdata;
    end

    // Register update with synchronous reset: all masked, level-low default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel <= '0;
            pol      <= '0;
            both     <= '0;
            mask     <= '1;
        end else begin
            mask <= mask_n;
            if (wr && addr == REG_EDGE) edge_sel <= wdata;
            if (wr && addr == REG_POL)  pol      <= wdata;
            if (wr && addr == REG_BOTH) both     <= wdata;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector.
// Compares each pin with its level on the previous clock for edge modes
// and uses the present level for level modes. Pins must already be
// synchronized to clk. The history register tracks the pins during reset
// too, so no edge is seen at reset release.
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  edge_sel,
    input  logic [NPINS-1:0]  pol,
    input  logic [NPINS-1:0]  both,
    output logic [NPINS-1:0]  evt
);
    logic [NPINS-1:0] prev_q;

    // Previous-cycle pin levels for edge comparison.
    always_ff @(posedge clk) begin
        prev_q <= pin_in;
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall, lvl_hit, edge_hit;

        // Per-pin event decode for the selected sensitivity.
        always_comb begin
            rise     = pin_in[i] & ~prev_q[i];
            fall     = ~pin_in[i] & prev_q[i];
            edge_hit = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
            lvl_hit  = pol[i] ? pin_in[i] : ~pin_in[i];
            evt[i]   = edge_sel[i] ? edge_hit : lvl_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
// Status latch and interrupt combiner.
// Events set status bits; write-1 clears them, and an event in the same
// cycle takes priority. irq is registered from status AND NOT mask.
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  evt,
    input  logic              clr_en,
    input  logic [NPINS-1:0]  clr_bits,
    input  logic [NPINS-1:0]  mask,
    output logic [NPINS-1:0]  status,
    output logic              irq
);
    logic [NPINS-1:0] status_n;

    // Next status: clear selected bits, then OR in new events.
    always_comb begin
        status_n = (status & ~(clr_en ? clr_bits : '0)) | evt;
    end

    // Status and irq registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_n;
            irq    <= |(status & ~mask);
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
// GPIO interrupt unit top.
// Decodes the register bus, wires configuration, detection and status, and
// returns registered read data. Assumes NPINS <= DATA_W.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              irq
);
    logic [NPINS-1:0]  edge_w, pol_w, both_w, mask_w, evt_w, status_w;
    logic [NPINS-1:0]  wdata_w;
    logic [NPINS-1:0]  rd_sel;
    logic [DATA_W-1:0] rd_word;
    logic              clr_en;

    assign wdata_w = bus_wdata[NPINS-1:0];
    assign clr_en  = bus_wr && (bus_addr == REG_STATUS);

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(wdata_w), .edge_sel(edge_w), .pol(pol_w), .both(both_w),
        .mask(mask_w)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .pin_in(pin_in), .edge_sel(edge_w), .pol(pol_w),
        .both(both_w), .evt(evt_w)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_sts (
        .clk(clk), .rst_n(rst_n), .evt(evt_w), .clr_en(clr_en),
        .clr_bits(wdata_w), .mask(mask_w), .status(status_w), .irq(irq)
    );

    // Readback selection; write-only and unused addresses return zero.
    always_comb begin
        case (bus_addr)
            REG_EDGE:   rd_sel = edge_w;
            REG_POL:    rd_sel = pol_w;
            REG_BOTH:   rd_sel = both_w;
            REG_MASK:   rd_sel = mask_w;
            REG_STATUS: rd_sel = status_w;
            default:    rd_sel = '0;
        endcase
        rd_word = '0;
        rd_word[NPINS-1:0] = rd_sel;
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
// Cycle-level checker for the GPIO interrupt unit, bound to the top.
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  mask,
    input logic [NPINS-1:0]  edge_sel,
    input logic [NPINS-1:0]  pol,
    input logic [NPINS-1:0]  both,
    input logic              irq
);
    logic pend;
    assign pend = |(status & ~mask);

    // R10
    irq_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(pend)));

    // R8
    status_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == REG_STATUS) |=> ((status & $past(status)) == $past(status)));

    // R3
    mask_only_by_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == REG_UNMASK || bus_addr == REG_MASKSET)) |=> $stable(mask));

    // R2
    cfg_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == REG_EDGE || bus_addr == REG_POL || bus_addr == REG_BOTH))
        |=> ($stable(edge_sel) && $stable(pol) && $stable(both)));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .status(status_w), .mask(mask_w), .edge_sel(edge_w), .pol(pol_w),
    .both(both_w), .irq(irq)
);

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
// Directed bench for gpio_irq_unit: one task per scenario.
module test_gpio_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '1;
    logic        irq;
    int checks = 0;
    int errors = 0;
    logic [31:0] e_cfg = '0, p_cfg = '0, b_cfg = '0;

    always #2 clk = ~clk;

    gpio_irq_unit i_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pins), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pins = v;
        @(negedge clk);
    endtask

    task automatic cfg_pin(input int i, input logic e, input logic p, input logic b);
        e_cfg[i] = e; p_cfg[i] = p; b_cfg[i] = b;
        bus_write(3'd0, e_cfg);
        bus_write(3'd1, p_cfg);
        bus_write(3'd2, b_cfg);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq in reset", {31'd0, irq}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        bus_read(3'd3, d); chk("R1 mask", d, 32'hFFFF_FFFF);
        bus_read(3'd6, d); chk("R1 status", d, 32'h0);
        bus_read(3'd0, d); chk("R1 edge cfg", d, 32'h0);
        bus_read(3'd1, d); chk("R1 pol cfg", d, 32'h0);
        bus_read(3'd2, d); chk("R1 both cfg", d, 32'h0);
        chk("R1 irq after release", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_cfg_rw();
        logic [31:0] d;
        bus_write(3'd0, 32'hA5A5_0F00);
        bus_read(3'd0, d); chk("R2 edge rw", d, 32'hA5A5_0F00);
        bus_write(3'd1, 32'h1234_5670);
        bus_read(3'd1, d); chk("R2 pol rw", d, 32'h1234_5670);
        bus_write(3'd2, 32'h8000_0000);
        bus_read(3'd2, d); chk("R2 both rw", d, 32'h8000_0000);
        bus_read(3'd4, d); chk("R2 unmask reads zero", d, 32'h0);
        bus_read(3'd5, d); chk("R2 maskset reads zero", d, 32'h0);
        // R11: rdata holds with no strobe even when the address moves
        @(negedge clk); bus_addr = 3'd1;
        @(negedge clk); chk("R11 rdata holds", bus_rdata, 32'h0);
        bus_write(3'd0, 32'h0); bus_write(3'd1, 32'h0); bus_write(3'd2, 32'h0);
        bus_write(3'd6, 32'hFFFF_FFFF);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_write(3'd4, 32'h0000_00FF);
        bus_read(3'd3, d); chk("R3 unmask bits", d, 32'hFFFF_FF00);
        bus_write(3'd5, 32'h0000_000F);
        bus_read(3'd3, d); chk("R3 set bits", d, 32'hFFFF_FF0F);
        bus_write(3'd4, 32'h0);
        bus_read(3'd3, d); chk("R3 zero write no change", d, 32'hFFFF_FF0F);
        bus_write(3'd5, 32'hFFFF_FFFF);
        bus_read(3'd3, d); chk("R3 mask all", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_rising();
        logic [31:0] d;
        cfg_pin(0, 1'b1, 1'b1, 1'b0);
        bus_write(3'd6, 32'hFFFF_FFFF);
        set_pins(pins & ~32'h1);
        bus_read(3'd6, d); chk("R4 no event on fall", d, 32'h0);
        set_pins(pins | 32'h1);
        bus_read(3'd6, d); chk("R4 rise latched", d, 32'h1);
        bus_write(3'd6, 32'h1);
    endtask

    task automatic t_falling();
        logic [31:0] d;
        cfg_pin(1, 1'b1, 1'b0, 1'b0);
        bus_write(3'd6, 32'hFFFF_FFFF);
        set_pins(pins & ~32'h2);
        bus_read(3'd6, d); chk("R5 fall latched", d, 32'h2);
        bus_write(3'd6, 32'h2);
        set_pins(pins | 32'h2);
        bus_read(3'd6, d); chk("R5 no event on rise", d, 32'h0);
    endtask

    task automatic t_both();
        logic [31:0] d;
        cfg_pin(2, 1'b1, 1'b1, 1'b1);
        bus_write(3'd6, 32'hFFFF_FFFF);
        set_pins(pins & ~32'h4);
        bus_read(3'd6, d); chk("R6 both fall with pol=1", d, 32'h4);
        bus_write(3'd6, 32'h4);
        set_pins(pins | 32'h4);
        bus_read(3'd6, d); chk("R6 both rise", d, 32'h4);
        bus_write(3'd6, 32'h4);
    endtask

    task automatic t_level();
        logic [31:0] d;
        cfg_pin(3, 1'b0, 1'b1, 1'b1);
        bus_read(3'd6, d); chk("R7 level high latched, both ignored", d, 32'h8);
        // Clear and new level event in the same cycle: the event wins.
        bus_write(3'd6, 32'h8);
        bus_read(3'd6, d); chk("R7 R8 clear overridden by active level", d, 32'h8);
        set_pins(pins & ~32'h8);
        bus_write(3'd6, 32'h8);
        bus_read(3'd6, d); chk("R7 cleared after level gone", d, 32'h0);
        cfg_pin(3, 1'b0, 1'b0, 1'b0);
        bus_read(3'd6, d); chk("R7 level low latched", d, 32'h8);
        set_pins(pins | 32'h8);
        bus_write(3'd6, 32'h8);
        bus_read(3'd6, d); chk("R7 level low released", d, 32'h0);
    endtask

    task automatic t_partial_clear();
        logic [31:0] d;
        set_pins(pins & ~32'h3);
        set_pins((pins | 32'h1) & ~32'h2);
        bus_read(3'd6, d); chk("R8 two events latched", d, 32'h3);
        bus_write(3'd6, 32'h1);
        bus_read(3'd6, d); chk("R8 only written bit cleared", d, 32'h2);
        set_pins(pins | 32'h2);
        bus_write(3'd6, 32'hFFFF_FFFF);
    endtask

    task automatic t_masked_irq();
        logic [31:0] d;
        // Pin 0 is in rising mode and every pin is masked.
        set_pins(pins & ~32'h1);
        set_pins(pins | 32'h1);
        @(negedge clk);
        chk("R9 irq low while masked", {31'd0, irq}, 32'd0);
        bus_read(3'd6, d); chk("R9 latched while masked", d, 32'h1);
        bus_write(3'd4, 32'h1);
        chk("R10 irq not yet after unmask", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R9 R10 irq one cycle after unmask", {31'd0, irq}, 32'd1);
        bus_write(3'd6, 32'h1);
        chk("R10 irq held one cycle after clear", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R10 irq drops after clear", {31'd0, irq}, 32'd0);
        // Unmasked pin: event to irq latency.
        set_pins(pins & ~32'h1);
        @(negedge clk); pins = pins | 32'h1;
        @(negedge clk);
        chk("R10 status set, irq not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R10 irq after unmasked event", {31'd0, irq}, 32'd1);
        // Masked event cleared before unmask gives no irq.
        bus_write(3'd5, 32'h1);
        bus_write(3'd6, 32'h1);
        set_pins(pins & ~32'h1);
        set_pins(pins | 32'h1);
        bus_write(3'd6, 32'h1);
        bus_write(3'd4, 32'h1);
        @(negedge clk); @(negedge clk);
        chk("R9 cleared before unmask, no irq", {31'd0, irq}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_cfg_rw();
        t_mask();
        t_rising();
        t_falling();
        t_both();
        t_level();
        t_partial_clear();
        t_masked_irq();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule